// File: doc/BRIEF.md
# Digitally Trimmed One-Second Divider

This block turns a clock-enable that pulses at a nominal 32,768 Hz into a one-cycle pulse per second. A plain count of 32,768 enables is divided into a first stage of 256 enables and a second stage of 128 stage periods. A slow crystal or a fast crystal is corrected without changing the divide ratio. Instead, single seconds are lengthened or shortened at the first stage, on a schedule that repeats every 64 minutes.

A six-bit trim word carries a magnitude N (0 to 31) and a direction. In each 64-minute cycle, the first 2N minutes each contain one corrected second: the first second of the minute. A forward correction drops one whole first-stage period of 256 enables, so that second ends early. A backward correction swallows 128 enables before counting starts, so that second runs long.

The block keeps its own second-of-minute and minute-of-cycle positions to place these corrections. It samples the trim word only at the start of each 64-minute cycle. A stop input holds all of it cleared. The oscillator itself and any calendar counting that consumes the tick sit outside the block.

Top module: `cal_trim_divider`

## Requirements
- R1: A synchronous active-high reset clears the divider and both position counters, holds `tick` low, and samples `cal_ctrl`; the first second after reset is second 0 of minute 0 of a new cycle.
- R2: With a trim magnitude of 0, every second lasts exactly PRE_DIV*STAGE_DIV enables (32,768 by default).
- R3: Only clock cycles with `osc_en` high advance the divider; `tick` is a one-cycle pulse raised in the cycle after the edge that consumes the last enable of a second.
- R4: With a forward trim, each corrected second lasts PRE_DIV*(STAGE_DIV-1) enables (256 fewer than nominal by default).
- R5: With a backward trim, each corrected second lasts PRE_DIV*STAGE_DIV + PRE_DIV/2 enables (128 more than nominal by default).
- R6: With magnitude N, the corrected seconds are second 0 of minutes 0 to 2N-1 of the 64-minute cycle; every other second is nominal.
- R7: Over one full cycle, the total enable count equals the nominal total minus 2*N*PRE_DIV for a forward trim, or plus N*PRE_DIV for a backward trim.
- R8: `cal_ctrl` is sampled only at the end of the last second of a cycle (and under reset or stop); a change at any other time has no effect until the next cycle starts.
- R9: While `stop` is high, no tick is produced and the divider and position counters stay cleared; after `stop` falls, counting restarts at second 0 of minute 0, using the trim sampled during stop.
- R10: `cal_ctrl[4:0]` is the trim magnitude in unsigned binary, and `cal_ctrl[5]` is the direction: 1 forward (shorter seconds), 0 backward (longer seconds).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| stop | input | 1 | Holds the divider cleared and silent while high |
| cal_ctrl | input | 6 | Trim word: bit 5 direction, bits 4:0 magnitude |
| tick | output | 1 | One-cycle pulse at the end of each second |

## Verification
The assertions assume that `osc_en` is a synchronous single-cycle qualifier that may stay high for many cycles, and that the stage parameters keep every corrected second at least two enables long. Under those assumptions, each second length is one of three legal values and depends only on the trim held for that second. The bench keeps to these assumptions by driving `osc_en`, `stop` and `cal_ctrl` only at falling clock edges, with a random enable density. It changes the trim word only between ticks, at random points inside a cycle, so that the delayed-sampling rule is exercised without ever changing the trim in mid-second.

// File: rtl/cal_div_pkg.sv
`timescale 1ns/1ps
package cal_div_pkg;

    localparam int CAL_MAG_W = 5;

    // Trim word as seen on the control input: direction above magnitude.
    typedef struct packed {
        logic                 fwd;
        logic [CAL_MAG_W-1:0] mag;
    } cal_cfg_t;

    typedef enum logic [1:0] {
        FIX_NONE    = 2'd0,
        FIX_SHORTEN = 2'd1,
        FIX_STRETCH = 2'd2
    } fix_kind_t;

    // Decide how the current second is treated from its position in the cycle.
    function automatic fix_kind_t pick_fix(input cal_cfg_t cfg,
                                           input logic first_sec,
                                           input logic [31:0] min_idx);
        logic [31:0] span;
        span = {{(32-CAL_MAG_W-1){1'b0}}, cfg.mag, 1'b0};
        if (!first_sec || (min_idx >= span)) begin
            return FIX_NONE;
        end
        return cfg.fwd ? FIX_SHORTEN : FIX_STRETCH;
    endfunction

endpackage

// File: rtl/cal_sampler.sv
`timescale 1ns/1ps
module cal_sampler
    import cal_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stop,
    input  logic     load,
    input  logic [5:0] cal_ctrl,
    output cal_cfg_t cfg
);

    // Trim is captured only at cycle boundaries, under reset, or while stopped.
    always_ff @(posedge clk) begin
        if (rst || stop || load) begin
            cfg <= cal_cfg_t'(cal_ctrl);
        end
    end

endmodule

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler
    import cal_div_pkg::*;
#(
    parameter int PRE_DIV   = 256,
    parameter int STAGE_DIV = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      stop,
    input  logic      osc_en,
    input  fix_kind_t fix,
    output logic      sec_done
);

    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam int STG_W = (STAGE_DIV > 1) ? $clog2(STAGE_DIV) : 1;
    localparam int BLANK = PRE_DIV / 2;
    localparam int BLK_W = $clog2(BLANK + 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [STG_W-1:0] stg_cnt;
    logic [BLK_W-1:0] blank_cnt;

    logic             blanking;
    logic             pre_last;
    logic [STG_W-1:0] last_stage;

    always_comb begin
        blanking   = (fix == FIX_STRETCH) && (blank_cnt < BLK_W'(BLANK));
        pre_last   = (pre_cnt == PRE_W'(PRE_DIV - 1));
        last_stage = (fix == FIX_SHORTEN) ? STG_W'(STAGE_DIV - 2)
                                          : STG_W'(STAGE_DIV - 1);
        sec_done   = !stop && osc_en && !blanking && pre_last &&
                     (stg_cnt == last_stage);
    end

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            pre_cnt   <= '0;
            stg_cnt   <= '0;
            blank_cnt <= '0;
        end else if (osc_en) begin
            if (blanking) begin
                blank_cnt <= blank_cnt + 1'b1;
            end else if (pre_last) begin
                pre_cnt <= '0;
                if (sec_done) begin
                    stg_cnt   <= '0;
                    blank_cnt <= '0;
                end else begin
                    stg_cnt <= stg_cnt + 1'b1;
                end
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cal_position.sv
`timescale 1ns/1ps
module cal_position
    import cal_div_pkg::*;
#(
    parameter int SECS_PER_MIN   = 60,
    parameter int MINS_PER_CYCLE = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      stop,
    input  logic      sec_done,
    input  cal_cfg_t  cfg,
    output fix_kind_t fix,
    output logic      cycle_end
);

    localparam int SEC_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
    localparam int MIN_W = (MINS_PER_CYCLE > 1) ? $clog2(MINS_PER_CYCLE) : 1;

    logic [SEC_W-1:0] sec_idx;
    logic [MIN_W-1:0] min_idx;
    logic             sec_last;
    logic             min_last;

    always_comb begin
        sec_last  = (sec_idx == SEC_W'(SECS_PER_MIN - 1));
        min_last  = (min_idx == MIN_W'(MINS_PER_CYCLE - 1));
        cycle_end = sec_last && min_last;
        fix       = pick_fix(cfg, (sec_idx == '0), 32'(min_idx));
    end

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            sec_idx <= '0;
            min_idx <= '0;
        end else if (sec_done) begin
            if (sec_last) begin
                sec_idx <= '0;
                min_idx <= min_last ? '0 : min_idx + 1'b1;
            end else begin
                sec_idx <= sec_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cal_trim_divider.sv
`timescale 1ns/1ps
module cal_trim_divider
    import cal_div_pkg::*;
#(
    parameter int PRE_DIV        = 256,
    parameter int STAGE_DIV      = 128,
    parameter int SECS_PER_MIN   = 60,
    parameter int MINS_PER_CYCLE = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_en,
    input  logic       stop,
    input  logic [5:0] cal_ctrl,
    output logic       tick
);

    cal_cfg_t  cal_q;
    fix_kind_t fix;
    logic      sec_done;
    logic      cycle_end;

    cal_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .stop     (stop),
        .load     (sec_done && cycle_end),
        .cal_ctrl (cal_ctrl),
        .cfg      (cal_q)
    );

    cal_prescaler #(
        .PRE_DIV   (PRE_DIV),
        .STAGE_DIV (STAGE_DIV)
    ) u_prescaler (
        .clk      (clk),
        .rst      (rst),
        .stop     (stop),
        .osc_en   (osc_en),
        .fix      (fix),
        .sec_done (sec_done)
    );

    cal_position #(
        .SECS_PER_MIN   (SECS_PER_MIN),
        .MINS_PER_CYCLE (MINS_PER_CYCLE)
    ) u_position (
        .clk       (clk),
        .rst       (rst),
        .stop      (stop),
        .sec_done  (sec_done),
        .cfg       (cal_q),
        .fix       (fix),
        .cycle_end (cycle_end)
    );

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            tick <= 1'b0;
        end else begin
            tick <= sec_done;
        end
    end

endmodule

// File: rtl/cal_trim_divider_chk.sv
`timescale 1ns/1ps
module cal_trim_divider_chk
    import cal_div_pkg::*;
#(
    parameter int PRE_DIV   = 256,
    parameter int STAGE_DIV = 128
) (
    input logic     clk,
    input logic     rst,
    input logic     stop,
    input logic     osc_en,
    input logic     tick,
    input cal_cfg_t cal_q
);

    localparam logic [31:0] NOM   = 32'(PRE_DIV * STAGE_DIV);
    localparam logic [31:0] SHORT = 32'(PRE_DIV * (STAGE_DIV - 1));
    localparam logic [31:0] LONG  = 32'(PRE_DIV * STAGE_DIV + PRE_DIV / 2);

    // Enables consumed since the last completed second.
    logic [31:0] seen;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            seen <= '0;
        end else if (tick) begin
            seen <= osc_en ? 32'd1 : 32'd0;
        end else if (osc_en) begin
            seen <= seen + 32'd1;
        end
    end

    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        stop |=> !tick);

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_tick_after_enable_R3: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(osc_en));

    assert_len_legal_R6: assert property (@(posedge clk) disable iff (rst)
        tick |-> (seen == NOM || seen == SHORT || seen == LONG));

    assert_zero_trim_nominal_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && ($past(cal_q.mag) == '0)) |-> (seen == NOM));

    assert_fwd_not_long_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && $past(cal_q.fwd)) |-> (seen != LONG));

    assert_bwd_not_short_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !$past(cal_q.fwd)) |-> (seen != SHORT));

    assert_len_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |-> (seen <= LONG));

endmodule

bind cal_trim_divider cal_trim_divider_chk #(
    .PRE_DIV   (PRE_DIV),
    .STAGE_DIV (STAGE_DIV)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .stop   (stop),
    .osc_en (osc_en),
    .tick   (tick),
    .cal_q  (cal_q)
);

// File: tb/sim_cal_trim_divider.sv
`timescale 1ns/1ps
module sim_cal_trim_divider;

    localparam int P   = 4;
    localparam int Q   = 4;
    localparam int SPM = 4;
    localparam int MPC = 64;
    localparam int NOM = P * Q;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b0;
    logic       stop = 1'b0;
    logic [5:0] cal_ctrl = 6'd0;
    logic       tick;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    int  m_sec, m_min, lat_mag, en_since, cyc_total;
    bit  lat_fwd;
    bit  first_after_stop;
    bit  prev_tick;

    cal_trim_divider #(
        .PRE_DIV        (P),
        .STAGE_DIV      (Q),
        .SECS_PER_MIN   (SPM),
        .MINS_PER_CYCLE (MPC)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .osc_en   (osc_en),
        .stop     (stop),
        .cal_ctrl (cal_ctrl),
        .tick     (tick)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below 190000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected second length from R2, R4, R5, R6, R10.
    function automatic int exp_len(input int s, input int m, input int mag, input bit fwd);
        if (s == 0 && m < 2 * mag) return fwd ? P * (Q - 1) : NOM + P / 2;
        return NOM;
    endfunction

    function automatic int exp_cycle(input int mag, input bit fwd);
        if (fwd) return NOM * SPM * MPC - 2 * mag * P;
        return NOM * SPM * MPC + mag * P;
    endfunction

    task automatic model_restart();
        m_sec = 0;
        m_min = 0;
        en_since = 0;
        cyc_total = 0;
        lat_mag = int'(cal_ctrl[4:0]);
        lat_fwd = cal_ctrl[5];
    endtask

    task automatic handle_tick();
        int    e;
        string tag;
        e = exp_len(m_sec, m_min, lat_mag, lat_fwd);
        if (first_after_stop) tag = "R9";
        else if (cal_ctrl != {lat_fwd, lat_mag[4:0]}) tag = "R8";
        else if (lat_mag == 0) tag = "R2";
        else if (e != NOM) tag = lat_fwd ? "R4 R10" : "R5 R10";
        else tag = "R6";
        chk(en_since == e, tag, en_since, e);
        first_after_stop = 1'b0;
        cyc_total = cyc_total + en_since;
        en_since = 0;
        if (m_sec == SPM - 1) begin
            m_sec = 0;
            if (m_min == MPC - 1) begin
                chk(cyc_total == exp_cycle(lat_mag, lat_fwd), "R7",
                    cyc_total, exp_cycle(lat_mag, lat_fwd));
                m_min = 0;
                cyc_total = 0;
                lat_mag = int'(cal_ctrl[4:0]);
                lat_fwd = cal_ctrl[5];
            end else begin
                m_min = m_min + 1;
            end
        end else begin
            m_sec = m_sec + 1;
        end
    endtask

    int ticks_seen = 0;

    task automatic step();
        @(negedge clk);
        if (tick) begin
            chk(!prev_tick, "R3 pulse width", 1, 0);
            handle_tick();
            ticks_seen = ticks_seen + 1;
        end
        prev_tick = tick;
        osc_en = (($urandom % 10) < 7);
        if (osc_en) en_since = en_since + 1;
    endtask

    task automatic run_ticks(input int n);
        int target;
        target = ticks_seen + n;
        while (ticks_seen < target) step();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        prev_tick = 1'b0;
        first_after_stop = 1'b0;
        // Reset with a forward trim of 1 (cal_ctrl[5]=1, [4:0]=1).
        cal_ctrl = 6'b1_00001;
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(tick == 1'b0, "R1 tick low in reset", tick, 0);
        end
        rst = 1'b0;
        osc_en = 1'b0;
        model_restart();
        // First tick after reset is the shortened second 0 of minute 0.
        run_ticks(1);
        chk(m_sec == 1 && m_min == 0, "R1 position after first second", m_sec, 1);
        // Mid-cycle writes: each takes effect at the next cycle (R8).
        run_ticks(40);
        cal_ctrl = 6'b0_00000;
        run_ticks(SPM * MPC - 41);
        run_ticks(100);
        cal_ctrl = 6'b1_11111;
        run_ticks(SPM * MPC - 100);
        run_ticks(7);
        cal_ctrl = 6'b0_11111;
        run_ticks(SPM * MPC - 7);
        run_ticks(200);
        cal_ctrl = 6'b1_00001;
        run_ticks(SPM * MPC - 200);
        run_ticks(30);
        // Stop: silent and cleared, then restart with a backward trim of 5.
        cal_ctrl = 6'b0_00101;
        stop = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(tick == 1'b0, "R9 no tick while stopped", tick, 0);
            osc_en = 1'b1;
        end
        stop = 1'b0;
        osc_en = 1'b0;
        prev_tick = 1'b0;
        model_restart();
        first_after_stop = 1'b1;
        run_ticks(SPM * MPC);
        // Random trim changes at random points.
        for (int c = 0; c < 3; c++) begin
            for (int t = 0; t < SPM * MPC; t++) begin
                run_ticks(1);
                if (($urandom % 64) == 0) cal_ctrl = 6'($urandom);
            end
        end
        summary();
    end

endmodule